// File: doc/BRIEF.md
# Buffered PWM Timer Channel

This block is a single channel of a general-purpose PWM timer. A 32-bit counter advances on ticks of a power-of-four prescaler and runs in one of three shapes: an upward sawtooth, a downward sawtooth, or an up/down triangle. Two active compare values each drive one output pin. The output levels are a function of the count, the active compare value and the counting shape.

Each compare value has a shadow register that the register bus writes. With buffering on, the shadow value moves into the active compare only at a waveform event. In the sawtooth shapes that event is the wrap point. In the triangle shape it is either the peak or the valley, chosen by a control bit. Choosing the peak lets the rising and falling halves of one triangle use different compare values, which gives laterally asymmetric PWM. With buffering off, a shadow write reaches the active compare at once.

The channel pulses an overflow flag when the count turns at the period and an underflow flag when it turns at zero. A synchronous clear input restarts the count and the prescaler.

Top module: `pwm_chan_top`

## Requirements
- R1: While reset is held, and right after it, the count is 0, both PWM outputs are low, and both flags are low. The reset mode is upward sawtooth, stopped, with prescale 0 and buffering off, and the period and all compare values are 0.
- R2: The counter takes one step per 4^p clocks, where p is the 3-bit prescale field. Values 6 and 7 act as 5. After a clear, the first step happens on the 4^p-th clock.
- R3: In upward sawtooth mode (mode code 0, code 3 behaves the same), the count goes 0,1,…,P and then returns to 0, where P is the period. The step from P (or above) to 0 raises ovf_o for exactly one cycle, in the same cycle the count shows 0.
- R4: In downward sawtooth mode (mode code 1), the count goes down to 0 and then reloads P. That reload raises unf_o for one cycle.
- R5: In triangle mode (mode code 2), the count rises to P, turns to P-1, falls to 0, and turns to 1. Each turn value is held for one step. The turn at P pulses ovf_o and the turn at 0 pulses unf_o. When P is 0 the count stays at 0.
- R6: While the run bit is 0, the count and the prescaler hold their values.
- R7: A high clr loads the count with 0, or with P in downward mode. It also resets the prescaler phase and sets the triangle direction to rising. It takes effect whether or not the channel is running, and it takes priority over counting and over buffer transfers.
- R8: Output n is high while count < compare_n in upward mode, while count > compare_n in downward mode, and while count >= compare_n in triangle mode.
- R9: With buffering on, a write to a shadow register does not change the output during the current cycle of the waveform. In the sawtooth modes the shadow value becomes active at the wrap step.
- R10: In triangle mode with buffering on, the transfer takes place at the turn at P when the crest-select bit is 1, and at the turn at 0 when it is 0.
- R11: With buffering off, a shadow write becomes the active compare value on the same clock edge as the write.
- R12: The bus is write-only, with writes taking effect on the clock edge while wr_en is high. Address 0 is control: bit0 run, bits2:1 mode, bits5:3 prescale, bit6 buffer enable, bit7 crest select. Address 1 is the period. Address 2 is shadow 0 and address 3 is shadow 1. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| clr | input | 1 | Synchronous counter clear |
| cnt_o | output | 32 | Current count |
| pwm_o | output | 2 | PWM output pins, bit n follows compare n |
| ovf_o | output | 1 | One-cycle pulse on a turn at the period |
| unf_o | output | 1 | One-cycle pulse on a turn at zero |

## Verification
Random sequences of register writes, in every mode, with short periods including 0, compares that lie above and below the period, mostly small prescales, and occasional clears are compared every cycle with a reference model. This shows whether the three shapes and the three output rules differ where they should. Directed runs check exact values. A divide-by-4 count after clear tells a wrong prescale step from a wrong phase restart. A shadow write in the middle of a cycle, checked before and after the wrap, tells buffered transfer apart from direct loading. A triangle whose compare changes at the crest shows whether transfer at the crest differs from transfer at the trough. A write with buffering off shows that the write takes effect on the same edge.

// File: rtl/pwm_chan_pkg.sv
`timescale 1ns/1ps
package pwm_chan_pkg;

    localparam int PS_W   = 3;
    localparam int PS_MAX = 5;
    localparam int PRE_W  = 2 * PS_MAX;

    localparam int ADR_CTRL = 0;
    localparam int ADR_PER  = 1;
    localparam int ADR_SH0  = 2;

    typedef enum logic [1:0] {
        CM_UP  = 2'd0,
        CM_DN  = 2'd1,
        CM_TRI = 2'd2
    } cnt_mode_e;

    // packed MSB first: bit7 crest, bit6 buf_en, bits5:3 ps, bits2:1 mode, bit0 run
    typedef struct packed {
        logic             crest_sel;
        logic             buf_en;
        logic [PS_W-1:0]  ps;
        cnt_mode_e        mode;
        logic             run;
    } ctrl_t;

    function automatic cnt_mode_e decode_mode(input logic [1:0] code);
        cnt_mode_e m;
        case (code)
            2'd1:    m = CM_DN;
            2'd2:    m = CM_TRI;
            default: m = CM_UP;
        endcase
        return m;
    endfunction

    function automatic logic [PRE_W-1:0] presc_limit(input logic [PS_W-1:0] ps);
        int p;
        p = int'(ps);
        if (p > PS_MAX) p = PS_MAX;
        return PRE_W'((1 << (2 * p)) - 1);
    endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
`timescale 1ns/1ps
module pwm_chan_regs
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3,
    parameter int N_OUT  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    output ctrl_t                        ctrl_q,
    output logic [CNT_W-1:0]             period_q,
    output logic [N_OUT-1:0]             sh_wr,
    output logic [N_OUT-1:0][CNT_W-1:0]  sh_q
);

    logic ctrl_hit;
    logic per_hit;

    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    assign per_hit  = wr_en && (wr_addr == ADDR_W'(ADR_PER));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '{crest_sel: 1'b0, buf_en: 1'b0, ps: '0, mode: CM_UP, run: 1'b0};
            period_q <= '0;
        end else begin
            if (ctrl_hit) begin
                ctrl_q <= '{crest_sel: wr_data[7],
                            buf_en:    wr_data[6],
                            ps:        wr_data[5:3],
                            mode:      decode_mode(wr_data[2:1]),
                            run:       wr_data[0]};
            end
            if (per_hit) period_q <= wr_data;
        end
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_shadow
        assign sh_wr[i] = wr_en && (wr_addr == ADDR_W'(ADR_SH0 + i));
        always_ff @(posedge clk) begin
            if (rst)           sh_q[i] <= '0;
            else if (sh_wr[i]) sh_q[i] <= wr_data;
        end
    end

endmodule

// File: rtl/pwm_chan_presc.sv
`timescale 1ns/1ps
module pwm_chan_presc
    import pwm_chan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    assign lim  = presc_limit(ps);
    assign tick = run && (pre_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr)  pre_q <= '0;
        else if (run)    pre_q <= tick ? '0 : pre_q + PRE_W'(1);
    end

    a_r6_presc_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(pre_q));

endmodule

// File: rtl/pwm_chan_counter.sv
`timescale 1ns/1ps
module pwm_chan_counter
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] period,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q,
    output logic             unf_q,
    output logic             xfer
);

    logic             rising_q;
    logic             at_top;
    logic             at_zero;
    logic             crest;
    logic             trough;
    logic [CNT_W-1:0] cnt_d;
    logic             rising_d;

    assign at_top  = (cnt_q >= period);
    assign at_zero = (cnt_q == '0);

    always_comb begin
        crest  = 1'b0;
        trough = 1'b0;
        case (ctrl.mode)
            CM_UP:   crest  = tick && at_top;
            CM_DN:   trough = tick && at_zero;
            default: begin
                crest  = tick &&  rising_q && at_top;
                trough = tick && !rising_q && at_zero;
            end
        endcase
    end

    always_comb begin
        if (!ctrl.buf_en || clr)       xfer = 1'b0;
        else if (ctrl.mode == CM_TRI)  xfer = ctrl.crest_sel ? crest : trough;
        else                           xfer = crest || trough;
    end

    always_comb begin
        cnt_d    = cnt_q;
        rising_d = rising_q;
        if (clr) begin
            cnt_d    = (ctrl.mode == CM_DN) ? period : '0;
            rising_d = 1'b1;
        end else if (tick) begin
            case (ctrl.mode)
                CM_UP: cnt_d = crest ? '0 : cnt_q + CNT_W'(1);
                CM_DN: cnt_d = trough ? period : cnt_q - CNT_W'(1);
                default: begin
                    if (rising_q) begin
                        if (crest) begin
                            rising_d = 1'b0;
                            cnt_d    = (period == '0) ? '0 : period - CNT_W'(1);
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end else begin
                        if (trough) begin
                            rising_d = 1'b1;
                            cnt_d    = (period == '0) ? '0 : CNT_W'(1);
                        end else begin
                            cnt_d = cnt_q - CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            rising_q <= 1'b1;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            rising_q <= rising_d;
            ovf_q    <= crest && !clr;
            unf_q    <= trough && !clr;
        end
    end

    a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !clr) |=> $stable(cnt_q));
    a_r2_no_step_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt_q));
    a_r7_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
        (clr && ctrl.mode != CM_DN) |=> (cnt_q == '0));
    a_r7_clear_to_period: assert property (@(posedge clk) disable iff (rst)
        (clr && ctrl.mode == CM_DN) |=> (cnt_q == $past(period)));
    a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && $past(ctrl.mode) == CM_UP) |-> (cnt_q == '0));
    a_r4_unf_reload: assert property (@(posedge clk) disable iff (rst)
        (unf_q && $past(ctrl.mode) == CM_DN) |-> (cnt_q == $past(period)));
    a_r5_one_flag: assert property (@(posedge clk) disable iff (rst)
        !(ovf_q && unf_q));

endmodule

// File: rtl/pwm_chan_cmp.sv
`timescale 1ns/1ps
module pwm_chan_cmp
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             buf_en,
    input  logic             xfer,
    input  logic             sh_wr,
    input  logic [CNT_W-1:0] sh_val,
    input  logic [CNT_W-1:0] wr_data,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] cnt,
    output logic             pwm
);

    logic [CNT_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst)                    cmp_q <= '0;
        else if (!buf_en && sh_wr)  cmp_q <= wr_data;
        else if (xfer)              cmp_q <= sh_val;
    end

    always_comb begin
        case (mode)
            CM_UP:   pwm = (cnt <  cmp_q);
            CM_DN:   pwm = (cnt >  cmp_q);
            default: pwm = (cnt >= cmp_q);
        endcase
    end

    a_r9_shadow_held: assert property (@(posedge clk) disable iff (rst)
        (buf_en && !xfer) |=> $stable(cmp_q));
    a_r11_direct_load: assert property (@(posedge clk) disable iff (rst)
        (!buf_en && sh_wr) |=> (cmp_q == $past(wr_data)));
    a_r10_xfer_loads_shadow: assert property (@(posedge clk) disable iff (rst)
        (xfer && !sh_wr) |=> (cmp_q == $past(sh_val)));

endmodule

// File: rtl/pwm_chan_top.sv
`timescale 1ns/1ps
module pwm_chan_top
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3,
    parameter int N_OUT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              clr,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [N_OUT-1:0]  pwm_o,
    output logic              ovf_o,
    output logic              unf_o
);

    ctrl_t                       ctrl_q;
    logic [CNT_W-1:0]            period_q;
    logic [N_OUT-1:0]            sh_wr;
    logic [N_OUT-1:0][CNT_W-1:0] sh_q;
    logic                        tick;
    logic                        xfer;

    pwm_chan_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .N_OUT(N_OUT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl_q   (ctrl_q),
        .period_q (period_q),
        .sh_wr    (sh_wr),
        .sh_q     (sh_q)
    );

    pwm_chan_presc u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .clr  (clr),
        .ps   (ctrl_q.ps),
        .tick (tick)
    );

    pwm_chan_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl_q),
        .period (period_q),
        .tick   (tick),
        .clr    (clr),
        .cnt_q  (cnt_o),
        .ovf_q  (ovf_o),
        .unf_q  (unf_o),
        .xfer   (xfer)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        pwm_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk     (clk),
            .rst     (rst),
            .buf_en  (ctrl_q.buf_en),
            .xfer    (xfer),
            .sh_wr   (sh_wr[i]),
            .sh_val  (sh_q[i]),
            .wr_data (wr_data),
            .mode    (ctrl_q.mode),
            .cnt     (cnt_o),
            .pwm     (pwm_o[i])
        );
    end

endmodule

// File: tb/pwm_chan_top_tb.sv
`timescale 1ns/1ps
module pwm_chan_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        clr = 1'b0;
    logic [31:0] cnt_o;
    logic [1:0]  pwm_o;
    logic        ovf_o;
    logic        unf_o;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_en = 1'b0;

    pwm_chan_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr(clr), .cnt_o(cnt_o), .pwm_o(pwm_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    always #10 clk = ~clk;

    // reference model state
    logic [31:0] m_cnt, m_per;
    logic [31:0] m_sh [2];
    logic [31:0] m_cmp [2];
    int          m_mode;
    logic [2:0]  m_ps;
    logic        m_run, m_buf, m_xc, m_up, m_ovf, m_unf;
    logic [10:0] m_pre;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_pwm(input int i);
        case (m_mode)
            0:       return m_cnt <  m_cmp[i];
            1:       return m_cnt >  m_cmp[i];
            default: return m_cnt >= m_cmp[i];
        endcase
    endfunction

    task automatic model_step();
        int p;
        logic [10:0] lim;
        logic tk, cr, tr, xf;
        p = int'(m_ps);
        if (p > 5) p = 5;
        lim = 11'((1 << (2 * p)) - 1);
        tk = m_run && (m_pre >= lim);
        cr = tk && ((m_mode == 0 && m_cnt >= m_per) || (m_mode == 2 && m_up && m_cnt >= m_per));
        tr = tk && ((m_mode == 1 && m_cnt == 0) || (m_mode == 2 && !m_up && m_cnt == 0));
        m_ovf = cr && !clr;
        m_unf = tr && !clr;
        xf = m_buf && !clr && ((m_mode == 2) ? (m_xc ? cr : tr) : (cr || tr));
        if (xf) begin
            m_cmp[0] = m_sh[0];
            m_cmp[1] = m_sh[1];
        end
        if (clr) begin
            m_cnt = (m_mode == 1) ? m_per : 32'd0;
            m_pre = '0;
            m_up  = 1'b1;
        end else if (m_run) begin
            m_pre = tk ? 11'd0 : m_pre + 11'd1;
            if (tk) begin
                case (m_mode)
                    0: m_cnt = cr ? 32'd0 : m_cnt + 1;
                    1: m_cnt = tr ? m_per : m_cnt - 1;
                    default: begin
                        if (m_up) begin
                            if (cr) begin m_up = 1'b0; m_cnt = (m_per == 0) ? 32'd0 : m_per - 1; end
                            else m_cnt = m_cnt + 1;
                        end else begin
                            if (tr) begin m_up = 1'b1; m_cnt = (m_per == 0) ? 32'd0 : 32'd1; end
                            else m_cnt = m_cnt - 1;
                        end
                    end
                endcase
            end
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0: begin
                    m_run = wr_data[0];
                    m_mode = (wr_data[2:1] == 2'd1) ? 1 : (wr_data[2:1] == 2'd2) ? 2 : 0;
                    m_ps = wr_data[5:3];
                    m_buf = wr_data[6];
                    m_xc = wr_data[7];
                end
                3'd1: m_per = wr_data;
                3'd2: begin if (!m_buf) m_cmp[0] = wr_data; m_sh[0] = wr_data; end
                3'd3: begin if (!m_buf) m_cmp[1] = wr_data; m_sh[1] = wr_data; end
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_per = 0; m_sh[0] = 0; m_sh[1] = 0; m_cmp[0] = 0; m_cmp[1] = 0;
            m_mode = 0; m_ps = 0; m_run = 0; m_buf = 0; m_xc = 0; m_up = 1;
            m_ovf = 0; m_unf = 0; m_pre = 0;
        end else begin
            model_step();
        end
    end

    always @(posedge clk) begin
        #5;
        if (cmp_en) begin
            chk("R2 R3 R4 R5 R6 R7 count", cnt_o, m_cnt);
            chk("R8 R9 R10 R11 R12 pwm0", 32'(pwm_o[0]), 32'(exp_pwm(0)));
            chk("R8 R9 R10 R11 R12 pwm1", 32'(pwm_o[1]), 32'(exp_pwm(1)));
            chk("R3 R4 R5 flags", {30'd0, ovf_o, unf_o}, {30'd0, m_ovf, m_unf});
        end
    end

    // tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // returns at a rising edge + 5 once the count equals v
    task automatic wait_cnt(input logic [31:0] v);
        for (int k = 0; k < 400; k++) begin
            @(posedge clk); #5;
            if (cnt_o == v) return;
        end
        chk("wait_cnt reach", cnt_o, v);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(20ns * 150000);
        n_err++;
        $display("FAIL watchdog all requirements: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #5;
        chk("R1 reset count", cnt_o, 32'd0);
        chk("R1 reset pwm", 32'(pwm_o), 32'd0);
        chk("R1 reset flags", {30'd0, ovf_o, unf_o}, 32'd0);
        cmp_en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset count", cnt_o, 32'd0);

        // R2 / R12: divide by 4 after clear
        wr(3'd1, 32'd100);
        wr(3'd0, 32'h09);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        repeat (40) @(posedge clk);
        #5;
        chk("R2 R12 divide-by-4 count", cnt_o, 32'd10);

        // R6: stop holds the count
        @(negedge clk);
        wr(3'd0, 32'h08);
        @(negedge clk);
        held = cnt_o;
        repeat (30) @(negedge clk);
        chk("R6 held count", cnt_o, held);

        // R7: clear in downward mode loads the period
        wr(3'd1, 32'd37);
        wr(3'd0, 32'h03);
        clr = 1'b1;
        @(posedge clk); #5;
        chk("R7 clear down loads period", cnt_o, 32'd37);
        @(negedge clk);
        clr = 1'b0;

        // R9 / R3: buffered write in upward sawtooth
        wr(3'd0, 32'h01);
        wr(3'd1, 32'd19);
        wr(3'd2, 32'd10);
        wr(3'd0, 32'h41);
        pulse_clr();
        wait_cnt(32'd5);
        chk("R9 pwm0 before write", 32'(pwm_o[0]), 32'd1);
        @(negedge clk);
        wr(3'd2, 32'd3);
        wait_cnt(32'd8);
        chk("R9 write ignored in current cycle", 32'(pwm_o[0]), 32'd1);
        wait_cnt(32'd0);
        chk("R3 overflow pulse at wrap", 32'(ovf_o), 32'd1);
        wait_cnt(32'd5);
        chk("R9 shadow active after wrap", 32'(pwm_o[0]), 32'd0);

        // R10: triangle, transfer at crest
        @(negedge clk);
        wr(3'd0, 32'h05);
        wr(3'd1, 32'd9);
        wr(3'd2, 32'd2);
        wr(3'd0, 32'hC5);
        pulse_clr();
        wait_cnt(32'd3);
        @(negedge clk);
        wr(3'd2, 32'd7);
        wait_cnt(32'd5);
        chk("R10 rising half uses old compare", 32'(pwm_o[0]), 32'd1);
        wait_cnt(32'd9);
        wait_cnt(32'd5);
        chk("R10 falling half uses crest transfer", 32'(pwm_o[0]), 32'd0);

        // R11: unbuffered write takes effect at once
        @(negedge clk);
        wr(3'd0, 32'h01);
        wr(3'd1, 32'd19);
        wr(3'd3, 32'd4);
        pulse_clr();
        wait_cnt(32'd6);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'd15;
        @(posedge clk); #5;
        chk("R11 direct compare load", 32'(pwm_o[1]), 32'd1);
        @(negedge clk);
        wr_en = 1'b0;

        // random phase, checked against the model every cycle
        for (int i = 0; i < 30000; i++) begin
            int r;
            @(negedge clk);
            r = int'($urandom % 100);
            wr_en = 1'b0;
            clr = (r < 2);
            if (r >= 2 && r < 14) begin
                int a;
                a = int'($urandom % 5);
                wr_en = 1'b1;
                wr_addr = 3'(a);
                case (a)
                    0: begin
                        logic [2:0] ps;
                        ps = (($urandom % 4) != 0) ? 3'($urandom % 2) : 3'($urandom % 8);
                        wr_data = {24'd0, 1'($urandom % 2), 1'($urandom % 2), ps,
                                   2'($urandom % 4), 1'(($urandom % 8) != 0)};
                    end
                    1: wr_data = $urandom % 25;
                    4: wr_data = $urandom;
                    default: wr_data = $urandom % 27;
                endcase
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        clr = 1'b0;
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule